// File: doc/BRIEF.md
# Low-Power Down-Counting System Timer

This block is a 32-bit down counter that gives an operating system its periodic or one-shot tick. The counter steps down by one on each pulse of a fixed 32768 Hz tick enable that is generated elsewhere. Software reaches the block through a single-cycle valid/write register bus. There are five registers: the live count (read-only), a reload value, a control word, an interrupt status bit and an interrupt enable bit.

A new count is taken from the reload register only when software raises the start bit from 0 to 1. A reload value written while the timer is running is held back until the next start. When the count steps from 1 to 0 it stays at zero and sets the status bit. The interrupt line is that status bit masked by the enable bit. Software can therefore tell a real expiry from a stale one: after a real expiry the count reads zero, and after a restart it does not. The count can also be frozen by an external debug-halt input when the control word permits it.

To restart the timer, software writes 0 to control, writes the reload value, and then writes enable and start together.

Top module: `lp_dcount_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: The count is loaded from the reload register only by a write that changes control bit 1 (start) from 0 to 1. Writing start=1 while start is already 1 leaves the count unchanged.
- R3: While control bit 0 (enable) and bit 1 (start) are both set, the count drops by exactly one on each cycle with `tick_en` high. It does not change on any other cycle.
- R4: Writing the reload register (offset 0x04) does not alter the running count. The register reads back the new value at once, and the value takes effect at the next start.
- R5: When control bit 2 (halt enable) is set and `dbg_halt` is high, ticks are ignored. When bit 2 is clear, `dbg_halt` has no effect.
- R6: A tick that moves the count from 1 to 0 sets status bit 0 (offset 0x0C). The count then stays at 0, and later ticks raise no new expiry.
- R7: With a reload value of 0, the first tick after start raises the expiry.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R9: `irq_o` is high exactly when status bit 0 and enable bit 0 (offset 0x10) are both set.
- R10: With enable clear, or after control is written to 0, the count holds its value through ticks.
- R11: Writes to the count offset (0x00) are ignored.
- R12: Reads from offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0. The control word reads back in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 32768 Hz |
| dbg_halt | input | 1 | Debug halt request from the processor |
| bus_vld | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench drives reload values of 0, 1, the all-ones word and mid-range values, and it ticks past zero. A design that wraps below zero, or that misses the expiry for a zero reload, shows a wrong count or a wrong status. A second start=1 write and a mid-run reload write are each followed by a count read, which catches a design that reloads on level instead of edge, or that applies the reload value early. Halt with and without the permit bit, enable low, and status writes of 0 and 1 each show up at the count, status and interrupt pins.

// File: rtl/lpt_pkg.sv
// Package: shared offsets and the control word layout for the system timer.
// Assumes byte offsets fit into the bus address width chosen by the top.
package lpt_pkg;
    localparam int OFS_COUNT  = 'h00;
    localparam int OFS_RELOAD = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_STAT   = 'h0C;
    localparam int OFS_IEN    = 'h10;

    // Control word: bit 2 halt permit, bit 1 start, bit 0 enable.
    typedef struct packed {
        logic halt_en;
        logic start;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lpt_regfile.sv
// Register decode: holds reload, control and interrupt enable, makes the
// start-edge load pulse and the status clear pulse, and muxes read data.
// Assumes one access per cycle and reads that need no bus_vld.
module lpt_regfile
    import lpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              stat_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] reload_q,
    output ctrl_t             ctrl_q,
    output logic              ien_q,
    output logic              load_p,
    output logic              stat_clr_p
);
    logic  wr_en;
    ctrl_t ctrl_new;

    assign wr_en    = bus_vld && bus_wr;
    assign ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    // Pulse that loads the counter on a 0 to 1 change of start.
    assign load_p = wr_en && (bus_addr == ADDR_W'(OFS_CTRL))
                    && ctrl_new.start && !ctrl_q.start;

    // Pulse that clears status when a 1 is written to bit 0.
    assign stat_clr_p = wr_en && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];

    // Writable registers; the count offset takes no write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            if (bus_addr == ADDR_W'(OFS_RELOAD)) reload_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_CTRL))   ctrl_q   <= ctrl_new;
            if (bus_addr == ADDR_W'(OFS_IEN))    ien_q    <= bus_wdata[0];
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_COUNT):  bus_rdata = cnt_i;
            ADDR_W'(OFS_RELOAD): bus_rdata = reload_q;
            ADDR_W'(OFS_CTRL):   bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_W'(OFS_STAT):   bus_rdata[0] = stat_i;
            ADDR_W'(OFS_IEN):    bus_rdata[0] = ien_q;
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_counter.sv
// Down counter: loads on the start pulse, steps on permitted ticks, stops
// at zero and flags one expiry per load. Assumes tick_en is a single-cycle pulse.
module lpt_counter
    import lpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_halt,
    input  ctrl_t             ctrl_i,
    input  logic              load_p,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire_p
);
    logic armed_q;
    logic advance;
    logic at_last;

    assign advance  = tick_en && ctrl_i.enable && ctrl_i.start
                      && !(ctrl_i.halt_en && dbg_halt);
    assign at_last  = (cnt_q <= DATA_W'(1));
    assign expire_p = advance && armed_q && at_last && !load_p;

    // Count register with load priority and a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_p) begin
            cnt_q   <= reload_i;
            armed_q <= 1'b1;
        end else if (advance) begin
            if (cnt_q != '0) cnt_q <= cnt_q - DATA_W'(1);
            if (expire_p)    armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lpt_irq.sv
// Interrupt source: status bit set by expiry, cleared by write-one, and
// masked by the enable bit. Assumes expiry takes priority over a clear.
module lpt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_p,
    input  logic stat_clr_p,
    input  logic ien_i,
    output logic stat_q,
    output logic irq_o
);
    // Sticky status with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_q <= 1'b0;
        else if (expire_p)   stat_q <= 1'b1;
        else if (stat_clr_p) stat_q <= 1'b0;
    end

    assign irq_o = stat_q && ien_i;
endmodule

// File: rtl/lp_dcount_timer.sv
// Top of the system timer: joins register decode, counter and interrupt
// source. Assumes tick_en is synchronous to clk.
module lp_dcount_timer
    import lpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_halt,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    ctrl_t             ctrl_q;
    logic              ien_q;
    logic              stat_q;
    logic              load_p;
    logic              stat_clr_p;
    logic              expire_p;

    lpt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_vld    (bus_vld),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_i      (cnt_q),
        .stat_i     (stat_q),
        .bus_rdata  (bus_rdata),
        .reload_q   (reload_q),
        .ctrl_q     (ctrl_q),
        .ien_q      (ien_q),
        .load_p     (load_p),
        .stat_clr_p (stat_clr_p)
    );

    lpt_counter #(.DATA_W(DATA_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .dbg_halt (dbg_halt),
        .ctrl_i   (ctrl_q),
        .load_p   (load_p),
        .reload_i (reload_q),
        .cnt_q    (cnt_q),
        .expire_p (expire_p)
    );

    lpt_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_p   (expire_p),
        .stat_clr_p (stat_clr_p),
        .ien_i      (ien_q),
        .stat_q     (stat_q),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/lpt_checker.sv
// Checker: temporal properties of the system timer, bound to the top.
// Assumes the bound signal names of lp_dcount_timer.
module lpt_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              dbg_halt,
    input logic              bus_vld,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic [DATA_W-1:0] cnt_q,
    input logic [2:0]        ctrl_bits,
    input logic              stat_q,
    input logic              ien_q,
    input logic              irq_o
);
    logic quiet;
    assign quiet = !(bus_vld && bus_wr);

    // R3, R11: without a tick or a write the count does not move.
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && quiet) |=> $stable(cnt_q));

    // R3: a permitted tick on a nonzero count removes exactly one.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ctrl_bits[0] && ctrl_bits[1] && !(ctrl_bits[2] && dbg_halt)
         && cnt_q != '0 && quiet) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));

    // R5: halt permit plus debug halt freezes the count.
    p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[2] && dbg_halt && quiet) |=> $stable(cnt_q));

    // R6: zero is a floor without a new start.
    p_zero_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && quiet) |=> (cnt_q == '0));

    // R10: enable clear holds the count.
    p_disabled_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[0] && quiet) |=> $stable(cnt_q));

    // R8: writing 0 to status keeps a set bit.
    p_w0_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_wr && bus_addr == ADDR_W'('h0C) && !wbit0 && stat_q) |=> stat_q);

    // R9: no request while the enable bit is clear.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq_o);
endmodule

bind lp_dcount_timer lpt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .dbg_halt  (dbg_halt),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wbit0     (bus_wdata[0]),
    .cnt_q     (cnt_q),
    .ctrl_bits (ctrl_q),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .irq_o     (irq_o)
);

// File: tb/test_lp_dcount_timer.sv
module test_lp_dcount_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [4:0] A_CNT = 5'h00, A_RLD = 5'h04, A_CTL = 5'h08,
                           A_STA = 5'h0C, A_IEN = 5'h10;

    // Vector table: reload, ticks after start, expected count, expected status.
    localparam logic [31:0] V_RLD [NV] = '{32'd10, 32'd5, 32'd5, 32'd1, 32'd0,
                                           32'd0, 32'h100, 32'hFFFF_FFFF};
    localparam int          V_TCK [NV] = '{3, 5, 8, 1, 1, 0, 16, 2};
    localparam logic [31:0] V_CNT [NV] = '{32'd7, 32'd0, 32'd0, 32'd0, 32'd0,
                                           32'd0, 32'hF0, 32'hFFFF_FFFD};
    localparam logic        V_STA [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b0, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_dcount_timer i_lp_dcount_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [31:0] v);
        wr(A_CTL, 32'd0);
        wr(A_RLD, v);
        wr(A_CTL, 32'd3);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CNT, rv); check("R1 count", rv, 0);
        rd(A_RLD, rv); check("R1 reload", rv, 0);
        rd(A_CTL, rv); check("R1 ctrl", rv, 0);
        rd(A_STA, rv); check("R1 status", rv, 0);
        rd(A_IEN, rv); check("R1 ien", rv, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R3/R6/R7: vector table
        for (int k = 0; k < NV; k++) begin
            wr(A_CTL, 32'd0);
            wr(A_STA, 32'd1);
            wr(A_RLD, V_RLD[k]);
            wr(A_CTL, 32'd3);
            ticks(V_TCK[k]);
            rd(A_CNT, rv); check($sformatf("R3/R7 row %0d count", k), rv, V_CNT[k]);
            rd(A_STA, rv); check($sformatf("R6/R7 row %0d status", k), rv, {31'd0, V_STA[k]});
        end

        // R6: zero floor and single expiry
        restart(32'd2);
        wr(A_STA, 32'd1);
        ticks(2);
        rd(A_STA, rv); check("R6 expiry set", rv, 1);
        wr(A_STA, 32'd1);
        ticks(3);
        rd(A_CNT, rv); check("R6 count stays zero", rv, 0);
        rd(A_STA, rv); check("R6 no second expiry", rv, 0);

        // R2: load only on start edge
        restart(32'd20);
        rd(A_CNT, rv); check("R2 loaded", rv, 20);
        ticks(1);
        wr(A_CTL, 32'd3);
        rd(A_CNT, rv); check("R2 start held no reload", rv, 19);
        wr(A_CTL, 32'd1);
        rd(A_CNT, rv); check("R2 start drop no reload", rv, 19);
        wr(A_CTL, 32'd3);
        rd(A_CNT, rv); check("R2 reload on edge", rv, 20);

        // R4: deferred reload
        ticks(2);
        wr(A_RLD, 32'd50);
        rd(A_CNT, rv); check("R4 count unchanged", rv, 18);
        rd(A_RLD, rv); check("R4 reload readback", rv, 50);
        wr(A_CTL, 32'd0);
        wr(A_CTL, 32'd3);
        rd(A_CNT, rv); check("R4 new value at start", rv, 50);

        // R5: debug halt
        wr(A_CTL, 32'd7);
        dbg_halt = 1'b1;
        ticks(3);
        rd(A_CNT, rv); check("R5 frozen", rv, 50);
        wr(A_CTL, 32'd3);
        ticks(2);
        rd(A_CNT, rv); check("R5 halt without permit", rv, 48);
        dbg_halt = 1'b0;

        // R10: enable clear and stop
        wr(A_CTL, 32'd2);
        ticks(2);
        rd(A_CNT, rv); check("R10 enable clear holds", rv, 48);
        wr(A_CTL, 32'd0);
        ticks(2);
        rd(A_CNT, rv); check("R10 stop holds", rv, 48);

        // R11: count is read-only
        wr(A_CNT, 32'd5);
        rd(A_CNT, rv); check("R11 write ignored", rv, 48);

        // R12: unmapped offsets and control readback
        rd(5'h14, rv); check("R12 offset 0x14", rv, 0);
        rd(5'h1C, rv); check("R12 offset 0x1C", rv, 0);
        wr(A_CTL, 32'hFFFF_FFFD);
        rd(A_CTL, rv); check("R12 ctrl bits", rv, 5);

        // R8/R9: status and interrupt mask
        restart(32'd0);
        ticks(1);
        rd(A_STA, rv); check("R8 status set", rv, 1);
        check("R9 masked", {31'd0, irq_o}, 0);
        wr(A_STA, 32'd0);
        rd(A_STA, rv); check("R8 write zero keeps", rv, 1);
        wr(A_IEN, 32'd1);
        check("R9 asserted", {31'd0, irq_o}, 1);
        wr(A_STA, 32'd1);
        rd(A_STA, rv); check("R8 write one clears", rv, 0);
        check("R9 released", {31'd0, irq_o}, 0);

        report();
    end
endmodule